// File: doc/BRIEF.md
# PHY Clock Switchover Sequencer

This block moves the clock source of a MAC's transmit and receive paths from one PHY to another (an on-chip PHY or an off-chip PHY) without producing a glitch on the clock. A bare select change could do that. Instead, the block runs a fixed safety sequence.

On a start request, the block first halts the transmitter and waits for it to report stopped. It then halts the receiver and waits for that to report stopped. Next it gates both PHY clocks off and holds them off for a minimum number of ticks of a reference that represents the slowest PHY clock. It then steers the port select to the target PHY, drives the clock select to that port and waits for the clocks to report running. Finally it releases the receiver, then the transmitter, and pulses done.

If a stop or run acknowledge does not arrive within a timeout, the sequencer raises an error flag. It then returns to idle with the clocks gated off.

The clock-gating cells and any PHY register programming sit outside this block. The block drives the clock select using these codes: internal 00, external 01, off 10. A consumer must treat 11 as off, and the block never drives 11.

The states are as follows:
- IDLE waits for a start.
- TX_STOP holds the transmitter halted and waits for its acknowledge.
- RX_STOP holds the receiver halted and waits for its acknowledge.
- CLK_GATE counts hold-off ticks.
- PORT_SEL is a single cycle after the port select has been updated.
- CLK_WAIT waits for clocks running.
- RX_RESUME is a single cycle after the receiver has been released.

The transitions are as follows:
- IDLE goes to TX_STOP on start.
- TX_STOP goes to RX_STOP on tx stopped.
- RX_STOP goes to CLK_GATE on rx stopped.
- CLK_GATE goes to PORT_SEL on the last hold-off tick.
- PORT_SEL always goes to CLK_WAIT.
- CLK_WAIT goes to RX_RESUME on clocks running.
- RX_RESUME always goes to IDLE, with done.
- TX_STOP, RX_STOP and CLK_WAIT each go to IDLE, with the error flag set, on timeout.

Top module: `phy_clk_switch_seq`

## Requirements
- R1: After reset, both halt requests are low, the port select is 0 and the clock select is 00 (internal). Busy, done and error are all low.
- R2: A start sampled in IDLE raises the transmit halt and busy on the next cycle. The receive halt stays low until the transmit stopped acknowledge is sampled.
- R3: The receive halt rises in the cycle after transmit stopped is sampled. The clock select keeps its value until receive stopped is sampled; in the next cycle it becomes 10 (off).
- R4: The port select does not change until HOLD_TICKS reference ticks (with a floor of 5) have been sampled while in CLK_GATE. Ticks sampled before the clocks were gated do not count.
- R5: The port select (1 = external) takes the target captured at start in the cycle after the last hold-off tick. One cycle later the clock select becomes 01 for external or 00 for internal. The port select changes only while the clock select is 10, and the clock select is never 11.
- R6: While the clocks-running acknowledge is low in CLK_WAIT, the clock select and both halts hold their values and busy stays high.
- R7: The receive halt falls in the cycle after clocks running is sampled. The transmit halt falls one cycle later.
- R8: Done is a one-cycle pulse, coincident with the transmit halt falling. Busy is low from that cycle on.
- R9: A start sampled while busy is ignored: the target captured at the accepted start is the one applied.
- R10: With every acknowledge already present and a tick on every cycle, done appears HOLD_TICKS+6 cycles after the start is sampled (the start cycle counts as 1).
- R11: If the block stays in TX_STOP, RX_STOP or CLK_WAIT for TIMEOUT_CYC cycles without its acknowledge, the next cycle shows error high, busy low and the clock select at 10. Both halts keep their values. The next accepted start clears error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a switchover (sampled in IDLE only) |
| target_ext_i | input | 1 | Target port: 1 = external PHY, 0 = internal PHY |
| tx_stopped_i | input | 1 | Transmitter reports it has stopped |
| rx_stopped_i | input | 1 | Receiver reports it has stopped |
| clk_running_i | input | 1 | Selected PHY clocks report running |
| slow_tick_i | input | 1 | One pulse per cycle of the slowest PHY clock |
| tx_halt_o | output | 1 | Transmit halt request |
| rx_halt_o | output | 1 | Receive halt request |
| ext_sel_o | output | 1 | Port select, 1 = external PHY |
| clk_sel_o | output | 2 | Clock select: 00 internal, 01 external, 10 off |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Acknowledge timeout flag, cleared by the next start |

## Verification
The bench targets the following corner cases:
- **Acknowledges held back for several cycles.** A sequencer that failed to wait would raise the receive halt, or gate the clocks, too early.
- **Ticks pulsed before gating.** A hold-off counter that ran outside CLK_GATE would steer the port after fewer than five gated ticks.
- **A second start with the opposite target during a sequence.** A sequencer that re-captured the target would end on the wrong port.
- **Exact completion latency with all acknowledges present.** This exposes a skipped or an extra state.
- **Timeouts in TX_STOP and CLK_WAIT.** A faulty timeout would either leave the clocks running, fire one cycle early or late, or keep error set after a fresh start.

// File: rtl/phy_sw_pkg.sv
package phy_sw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_STOP,
        ST_RX_STOP,
        ST_CLK_GATE,
        ST_PORT_SEL,
        ST_CLK_WAIT,
        ST_RX_RESUME
    } sw_state_e;

    localparam logic [1:0] CSEL_INT = 2'b00;
    localparam logic [1:0] CSEL_EXT = 2'b01;
    localparam logic [1:0] CSEL_OFF = 2'b10;

    localparam int unsigned HOLD_FLOOR = 5;

    // One-cycle strobes from the sequencer to the control registers
    typedef struct packed {
        logic accept;
        logic set_tx_halt;
        logic set_rx_halt;
        logic gate_off;
        logic load_port;
        logic clk_on;
        logic clr_rx_halt;
        logic clr_tx_halt;
        logic finish;
        logic fault;
    } sw_cmd_t;

    function automatic logic [1:0] csel_for(input logic ext);
        return ext ? CSEL_EXT : CSEL_INT;
    endfunction

endpackage

// File: rtl/sw_holdoff_cnt.sv
module sw_holdoff_cnt #(
    parameter int unsigned HOLD_TICKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    output logic reached
);
    import phy_sw_pkg::*;

    localparam int unsigned HOLD_EFF = (HOLD_TICKS < HOLD_FLOOR) ? HOLD_FLOOR : HOLD_TICKS;
    localparam int unsigned CW       = $clog2(HOLD_EFF + 1);
    localparam logic [CW-1:0] LAST   = CW'(HOLD_EFF - 1);

    logic [CW-1:0] cnt_q;

    // Counting only happens inside the gated window; outside it the count rests at zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign reached = enable && tick && (cnt_q == LAST);

endmodule

// File: rtl/sw_wait_timer.sv
module sw_wait_timer #(
    parameter int unsigned LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam int unsigned LIM_EFF = (LIMIT < 2) ? 2 : LIMIT;
    localparam int unsigned TW      = $clog2(LIM_EFF + 1);
    localparam logic [TW-1:0] LAST  = TW'(LIM_EFF - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/sw_ctrl_regs.sv
module sw_ctrl_regs (
    input  logic                  clk,
    input  logic                  rst_n,
    input  phy_sw_pkg::sw_cmd_t   cmd,
    input  logic                  target_ext,
    output logic                  tx_halt,
    output logic                  rx_halt,
    output logic                  ext_sel,
    output logic [1:0]            clk_sel,
    output logic                  done,
    output logic                  err
);
    import phy_sw_pkg::*;

    logic target_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= 1'b0;
            tx_halt  <= 1'b0;
            rx_halt  <= 1'b0;
            ext_sel  <= 1'b0;
            clk_sel  <= CSEL_INT;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= cmd.finish;
            if (cmd.accept) begin
                target_q <= target_ext;
                err      <= 1'b0;
            end
            if (cmd.fault) begin
                err <= 1'b1;
            end
            if (cmd.set_tx_halt) begin
                tx_halt <= 1'b1;
            end else if (cmd.clr_tx_halt) begin
                tx_halt <= 1'b0;
            end
            if (cmd.set_rx_halt) begin
                rx_halt <= 1'b1;
            end else if (cmd.clr_rx_halt) begin
                rx_halt <= 1'b0;
            end
            if (cmd.load_port) begin
                ext_sel <= target_q;
            end
            if (cmd.gate_off) begin
                clk_sel <= CSEL_OFF;
            end else if (cmd.clk_on) begin
                clk_sel <= csel_for(ext_sel);
            end
        end
    end

endmodule

// File: rtl/phy_clk_switch_seq.sv
module phy_clk_switch_seq #(
    parameter int unsigned HOLD_TICKS  = 5,
    parameter int unsigned TIMEOUT_CYC = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       target_ext_i,
    input  logic       tx_stopped_i,
    input  logic       rx_stopped_i,
    input  logic       clk_running_i,
    input  logic       slow_tick_i,
    output logic       tx_halt_o,
    output logic       rx_halt_o,
    output logic       ext_sel_o,
    output logic [1:0] clk_sel_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o
);
    import phy_sw_pkg::*;

    sw_state_e state_q, state_d;
    sw_cmd_t   cmd;
    logic      hold_done;
    logic      waiting;
    logic      ack;
    logic      timed_out;

    // Acknowledge that the current wait state is looking for
    always_comb begin
        waiting = 1'b0;
        ack     = 1'b0;
        unique case (state_q)
            ST_TX_STOP:  begin waiting = 1'b1; ack = tx_stopped_i;  end
            ST_RX_STOP:  begin waiting = 1'b1; ack = rx_stopped_i;  end
            ST_CLK_WAIT: begin waiting = 1'b1; ack = clk_running_i; end
            ST_IDLE, ST_CLK_GATE, ST_PORT_SEL, ST_RX_RESUME: begin
                waiting = 1'b0;
                ack     = 1'b0;
            end
        endcase
    end

    sw_holdoff_cnt #(
        .HOLD_TICKS(HOLD_TICKS)
    ) holdoff_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (state_q == ST_CLK_GATE),
        .tick    (slow_tick_i),
        .reached (hold_done)
    );

    sw_wait_timer #(
        .LIMIT(TIMEOUT_CYC)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (waiting),
        .restart (state_d != state_q),
        .expired (timed_out)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_TX_STOP;
            ST_TX_STOP:   if (ack) state_d = ST_RX_STOP;
                          else if (timed_out) state_d = ST_IDLE;
            ST_RX_STOP:   if (ack) state_d = ST_CLK_GATE;
                          else if (timed_out) state_d = ST_IDLE;
            ST_CLK_GATE:  if (hold_done) state_d = ST_PORT_SEL;
            ST_PORT_SEL:  state_d = ST_CLK_WAIT;
            ST_CLK_WAIT:  if (ack) state_d = ST_RX_RESUME;
                          else if (timed_out) state_d = ST_IDLE;
            ST_RX_RESUME: state_d = ST_IDLE;
        endcase
    end

    // Output strobes
    always_comb begin
        cmd       = '0;
        cmd.fault = waiting && !ack && timed_out;
        unique case (state_q)
            ST_IDLE: begin
                cmd.accept      = start_i;
                cmd.set_tx_halt = start_i;
            end
            ST_TX_STOP: begin
                cmd.set_rx_halt = ack;
            end
            ST_RX_STOP: begin
                cmd.gate_off = ack;
            end
            ST_CLK_GATE: begin
                cmd.load_port = hold_done;
            end
            ST_PORT_SEL: begin
                cmd.clk_on = 1'b1;
            end
            ST_CLK_WAIT: begin
                cmd.clr_rx_halt = ack;
            end
            ST_RX_RESUME: begin
                cmd.clr_tx_halt = 1'b1;
                cmd.finish      = 1'b1;
            end
        endcase
        if (cmd.fault) begin
            cmd.gate_off = 1'b1;
        end
    end

    sw_ctrl_regs regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .target_ext (target_ext_i),
        .tx_halt    (tx_halt_o),
        .rx_halt    (rx_halt_o),
        .ext_sel    (ext_sel_o),
        .clk_sel    (clk_sel_o),
        .done       (done_o),
        .err        (err_o)
    );

    assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/phy_clk_switch_seq_chk.sv
module phy_clk_switch_seq_chk #(
    parameter int unsigned HOLD_TICKS = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       slow_tick_i,
    input logic       tx_halt_o,
    input logic       rx_halt_o,
    input logic       ext_sel_o,
    input logic [1:0] clk_sel_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o
);
    localparam int unsigned HOLD_EFF = (HOLD_TICKS < 5) ? 5 : HOLD_TICKS;

    logic [15:0] gated_ticks;

    // Ticks seen while the clock select reads off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gated_ticks <= '0;
        end else if (clk_sel_o != 2'b10) begin
            gated_ticks <= '0;
        end else if (slow_tick_i && (gated_ticks != 16'hFFFF)) begin
            gated_ticks <= gated_ticks + 16'd1;
        end
    end

    AST_RX_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_halt_o) |-> tx_halt_o); // R2

    AST_GATE_NEEDS_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_sel_o == 2'b10) && ($past(clk_sel_o) != 2'b10) && !err_o) |-> (tx_halt_o && rx_halt_o)); // R3

    AST_HOLDOFF_MET: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(clk_sel_o) == 2'b10) && (clk_sel_o != 2'b10)) |-> (gated_ticks >= 16'(HOLD_EFF))); // R4

    AST_PORT_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ext_sel_o) |-> ((clk_sel_o == 2'b10) && ($past(clk_sel_o) == 2'b10))); // R5

    AST_NO_CODE3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (clk_sel_o != 2'b11)); // R5

    AST_TX_AFTER_RX: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_halt_o) |-> (!rx_halt_o && !$past(rx_halt_o) && done_o)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R8

    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> ((clk_sel_o == 2'b10) && !busy_o)); // R11

endmodule

bind phy_clk_switch_seq phy_clk_switch_seq_chk #(
    .HOLD_TICKS(HOLD_TICKS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .slow_tick_i (slow_tick_i),
    .tx_halt_o   (tx_halt_o),
    .rx_halt_o   (rx_halt_o),
    .ext_sel_o   (ext_sel_o),
    .clk_sel_o   (clk_sel_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/phy_clk_switch_seq_tb_top.sv
`timescale 1ns/1ps
module phy_clk_switch_seq_tb_top;

    localparam int unsigned HOLD  = 5;
    localparam int unsigned LIMIT = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       target_ext_i = 1'b0;
    logic       tx_stopped_i = 1'b0;
    logic       rx_stopped_i = 1'b0;
    logic       clk_running_i = 1'b0;
    logic       slow_tick_i = 1'b0;
    logic       tx_halt_o, rx_halt_o, ext_sel_o, busy_o, done_o, err_o;
    logic [1:0] clk_sel_o;

    int checks = 0;
    int failures = 0;
    bit reported = 1'b0;

    always #10 clk = ~clk;

    phy_clk_switch_seq #(
        .HOLD_TICKS (HOLD),
        .TIMEOUT_CYC(LIMIT)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .target_ext_i (target_ext_i),
        .tx_stopped_i (tx_stopped_i),
        .rx_stopped_i (rx_stopped_i),
        .clk_running_i(clk_running_i),
        .slow_tick_i  (slow_tick_i),
        .tx_halt_o    (tx_halt_o),
        .rx_halt_o    (rx_halt_o),
        .ext_sel_o    (ext_sel_o),
        .clk_sel_o    (clk_sel_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic clear_acks();
        tx_stopped_i = 1'b0; rx_stopped_i = 1'b0; clk_running_i = 1'b0; slow_tick_i = 1'b0;
    endtask

    // R1
    task automatic t_reset();
        check("R1", "tx_halt", tx_halt_o, 0);
        check("R1", "rx_halt", rx_halt_o, 0);
        check("R1", "ext_sel", ext_sel_o, 0);
        check("R1", "clk_sel", clk_sel_o, 0);
        check("R1", "busy", busy_o, 0);
        check("R1", "done", done_o, 0);
        check("R1", "err", err_o, 0);
    endtask

    // Slow acknowledges, switch to external, with a stray start mid-sequence
    task automatic t_slow_to_ext();
        target_ext_i = 1'b1; start_i = 1'b1;
        step();
        start_i = 1'b0;
        check("R2", "tx_halt after start", tx_halt_o, 1);
        check("R2", "busy after start", busy_o, 1);
        check("R2", "rx_halt before tx stop", rx_halt_o, 0);
        target_ext_i = 1'b0; start_i = 1'b1;     // R9: ignored request
        slow_tick_i = 1'b1;                       // R4: ticks before gating
        step();
        start_i = 1'b0;
        step(2);
        slow_tick_i = 1'b0;
        check("R2", "rx_halt still low", rx_halt_o, 0);
        tx_stopped_i = 1'b1;
        step();
        check("R3", "rx_halt after tx stop", rx_halt_o, 1);
        check("R3", "clk_sel before rx stop", clk_sel_o, 0);
        slow_tick_i = 1'b1;
        step(2);
        slow_tick_i = 1'b0;
        check("R3", "clk_sel held", clk_sel_o, 0);
        rx_stopped_i = 1'b1;
        step();
        check("R3", "clk_sel off", clk_sel_o, 2);
        for (int k = 0; k < HOLD - 1; k++) begin
            slow_tick_i = 1'b1; step();
            slow_tick_i = 1'b0; step();
        end
        check("R4", "ext_sel before last tick", ext_sel_o, 0);
        check("R4", "clk_sel before last tick", clk_sel_o, 2);
        slow_tick_i = 1'b1; step();
        slow_tick_i = 1'b0;
        check("R5", "ext_sel loaded", ext_sel_o, 1);
        check("R5", "clk_sel still off", clk_sel_o, 2);
        step();
        check("R5", "clk_sel external", clk_sel_o, 1);
        step(3);
        check("R6", "clk_sel held", clk_sel_o, 1);
        check("R6", "rx_halt held", rx_halt_o, 1);
        check("R6", "tx_halt held", tx_halt_o, 1);
        check("R6", "busy held", busy_o, 1);
        clk_running_i = 1'b1;
        step();
        check("R7", "rx_halt released", rx_halt_o, 0);
        check("R7", "tx_halt still set", tx_halt_o, 1);
        step();
        check("R7", "tx_halt released", tx_halt_o, 0);
        check("R8", "done pulse", done_o, 1);
        check("R8", "busy low", busy_o, 0);
        step();
        check("R8", "done one cycle", done_o, 0);
        check("R9", "target kept", ext_sel_o, 1);
        clear_acks();
        step();
    endtask

    // R10: everything present, back to internal
    task automatic t_fast_to_int();
        int n;
        tx_stopped_i = 1'b1; rx_stopped_i = 1'b1; clk_running_i = 1'b1; slow_tick_i = 1'b1;
        target_ext_i = 1'b0; start_i = 1'b1;
        step();
        start_i = 1'b0;
        n = 1;
        while (!done_o && n < 60) begin
            step();
            n++;
        end
        check("R10", "latency", n, HOLD + 6);
        check("R10", "ext_sel internal", ext_sel_o, 0);
        check("R10", "clk_sel internal", clk_sel_o, 0);
        clear_acks();
        step();
    endtask

    // R11: timeout while waiting for tx stopped, then recovery
    task automatic t_timeout_tx();
        target_ext_i = 1'b1; start_i = 1'b1;
        step();
        start_i = 1'b0;
        step(LIMIT - 1);
        check("R11", "err before limit", err_o, 0);
        check("R11", "busy before limit", busy_o, 1);
        step();
        check("R11", "err set", err_o, 1);
        check("R11", "busy low", busy_o, 0);
        check("R11", "clk_sel off", clk_sel_o, 2);
        check("R11", "tx_halt kept", tx_halt_o, 1);
        check("R11", "rx_halt kept", rx_halt_o, 0);
        tx_stopped_i = 1'b1; rx_stopped_i = 1'b1; clk_running_i = 1'b1; slow_tick_i = 1'b1;
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        check("R11", "err cleared by start", err_o, 0);
        for (int k = 0; k < 40 && !done_o; k++) step();
        check("R11", "recovered done", done_o, 1);
        check("R11", "recovered clk_sel", clk_sel_o, 1);
        clear_acks();
        step();
    endtask

    // R11: timeout while waiting for clocks running
    task automatic t_timeout_clk();
        tx_stopped_i = 1'b1; rx_stopped_i = 1'b1; slow_tick_i = 1'b1;
        target_ext_i = 1'b0; start_i = 1'b1;
        step();
        start_i = 1'b0;
        for (int k = 0; k < 100 && !err_o; k++) step();
        check("R11", "clk wait err", err_o, 1);
        check("R11", "clk wait clk_sel off", clk_sel_o, 2);
        check("R11", "clk wait rx_halt kept", rx_halt_o, 1);
        check("R11", "clk wait tx_halt kept", tx_halt_o, 1);
        check("R11", "clk wait busy", busy_o, 0);
        check("R11", "clk wait no done", done_o, 0);
        clear_acks();
        step();
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_slow_to_ext();
        t_fast_to_int();
        t_timeout_tx();
        t_timeout_clk();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

endmodule